// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block takes divider settings for a frequency synthesizer from a three-wire serial link: a serial clock, a serial data line and a load strobe. All three wires are brought into the block's own clock domain through a synchronizer, and edges are found there. Each rising serial clock edge moves one data bit into an 18-bit shift register. The frame is sent most significant bit first: first the 5-bit input prescaler, then the 3-bit output divider code, then the 10-bit feedback divider.

The parallel fields that drive the dividers change only on a rising edge of the load strobe. On that edge the whole assembled word is copied into the holding registers in a single cycle, so the dividers never see a word that is only partly updated. A one-cycle update pulse marks each copy. After reset the holding registers read prescaler 1, output divider code 0 (divide by two) and feedback divider 1.

Top module: `cfgl_serial_loader`

## Requirements
- R1: During and right after reset the outputs are pre_div = 1, post_code = 0, fb_div = 1 and cfg_upd = 0.
- R2: Each rising edge of ser_clk shifts in one ser_dat bit. After 18 bits and a load, the first bit sent is pre_div[4] and the last is fb_div[0]. The wire order is pre_div[4:0], then post_code[2:0], then fb_div[9:0], each field MSB first.
- R3: Shifting bits with no rising edge of ser_ld leaves pre_div, post_code and fb_div unchanged.
- R4: A rising edge of ser_ld updates all three fields together. They take their new values at the third rising clk edge after ser_ld goes high, and keep their old values until then.
- R5: cfg_upd is high for exactly one clk cycle, in the same cycle that the fields take their new values.
- R6: If more than 18 bits are shifted before a load, only the last 18 bits sent are loaded.
- R7: Holding ser_ld high does not cause another update, and a falling edge of ser_ld causes none either.
- R8: A load with no new bits shifted since the last load loads the same word again and raises cfg_upd again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples all serial wires |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock; a bit is taken on its rising edge |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Load strobe; its rising edge commits the word |
| pre_div | output | 5 | Input prescaler value |
| post_code | output | 3 | Output divider code |
| fb_div | output | 10 | Feedback divider value |
| cfg_upd | output | 1 | One-cycle pulse that marks a new setting |

## Verification
A wire change reaches the edge detector after two synchronizer stages. The holding registers and cfg_upd then change on the third rising clk edge after ser_ld rises. The bench sets its inputs on falling clk edges and samples 1 ns after a rising edge. After the second rising edge it checks that the old fields are still held and cfg_upd is low. After the third it checks the new fields and the pulse, and one cycle later that the pulse has dropped. Each bit is held for three cycles with ser_clk low and three with it high, so the synchronized data is settled before the synchronized clock edge.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   localparam int unsigned PRE_W_DEF  = 5;
   localparam int unsigned POST_W_DEF = 3;
   localparam int unsigned FB_W_DEF   = 10;
   localparam int unsigned SYNC_DEF   = 2;
   localparam int unsigned PRE_RST    = 1;
   localparam int unsigned POST_RST   = 0;
   localparam int unsigned FB_RST     = 1;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
   parameter int unsigned WID    = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [WID-1:0] din,
   output logic [WID-1:0] dout
);
   initial begin
      assert (STAGES >= 2) else $error("cfgl_sync: STAGES must be at least 2");
      assert (WID >= 1) else $error("cfgl_sync: WID must be at least 1");
   end

   logic [WID-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfgl_rise.sv
module cfgl_rise #(
   parameter int unsigned WID = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [WID-1:0] lvl,
   output logic [WID-1:0] rise
);
   logic [WID-1:0] prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
   parameter int unsigned W         = 18,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] word
);
   initial begin
      assert (W >= 2) else $error("cfgl_shifter: W must be at least 2");
   end

   logic [W-1:0] nxt;

   if (MSB_FIRST) begin : g_msb
      assign nxt = {word[W-2:0], din};
   end else begin : g_lsb
      assign nxt = {din, word[W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= nxt;
   end
endmodule

// File: rtl/cfgl_hold.sv
module cfgl_hold #(
   parameter int unsigned PRE_W    = 5,
   parameter int unsigned POST_W   = 3,
   parameter int unsigned FB_W     = 10,
   parameter int unsigned PRE_RST  = 1,
   parameter int unsigned POST_RST = 0,
   parameter int unsigned FB_RST   = 1,
   localparam int unsigned W       = PRE_W + POST_W + FB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [W-1:0]      word,
   output logic [PRE_W-1:0]  pre_q,
   output logic [POST_W-1:0] post_q,
   output logic [FB_W-1:0]   fb_q,
   output logic              upd_q
);
   initial begin
      assert (PRE_RST < (2 ** PRE_W)) else $error("cfgl_hold: PRE_RST too wide");
      assert (POST_RST < (2 ** POST_W)) else $error("cfgl_hold: POST_RST too wide");
      assert (FB_RST < (2 ** FB_W)) else $error("cfgl_hold: FB_RST too wide");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q  <= PRE_W'(PRE_RST);
         post_q <= POST_W'(POST_RST);
         fb_q   <= FB_W'(FB_RST);
         upd_q  <= 1'b0;
      end else begin
         upd_q <= commit;
         if (commit) begin
            pre_q  <= word[W-1 -: PRE_W];
            post_q <= word[FB_W +: POST_W];
            fb_q   <= word[FB_W-1:0];
         end
      end
   end
endmodule

// File: rtl/cfgl_serial_loader.sv
module cfgl_serial_loader #(
   parameter int unsigned PRE_W       = cfgl_pkg::PRE_W_DEF,
   parameter int unsigned POST_W      = cfgl_pkg::POST_W_DEF,
   parameter int unsigned FB_W        = cfgl_pkg::FB_W_DEF,
   parameter int unsigned SYNC_STAGES = cfgl_pkg::SYNC_DEF,
   parameter bit          MSB_FIRST   = 1'b1,
   parameter bit          LD_ACT_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_ld,
   output logic [PRE_W-1:0]  pre_div,
   output logic [POST_W-1:0] post_code,
   output logic [FB_W-1:0]   fb_div,
   output logic              cfg_upd
);
   localparam int unsigned FRAME_W = PRE_W + POST_W + FB_W;

   initial begin
      assert (PRE_W >= 1 && POST_W >= 1 && FB_W >= 1)
         else $error("cfgl_serial_loader: every field needs at least one bit");
   end

   logic         ld_norm;
   logic [2:0]   raw_v, syn_v;
   logic [1:0]   edg;
   logic         sclk_rise, load_rise, din_s;
   logic [FRAME_W-1:0] word;

   if (LD_ACT_HIGH) begin : g_ld_hi
      assign ld_norm = ser_ld;
   end else begin : g_ld_lo
      assign ld_norm = ~ser_ld;
   end

   assign raw_v = {ld_norm, ser_dat, ser_clk};

   cfgl_sync #(.WID(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_v), .dout(syn_v)
   );

   cfgl_rise #(.WID(2)) u_rise (
      .clk(clk), .rst_n(rst_n), .lvl({syn_v[2], syn_v[0]}), .rise(edg)
   );

   assign sclk_rise = edg[0];
   assign load_rise = edg[1];
   assign din_s     = syn_v[1];

   cfgl_shifter #(.W(FRAME_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .din(din_s), .word(word)
   );

   cfgl_hold #(
      .PRE_W(PRE_W), .POST_W(POST_W), .FB_W(FB_W),
      .PRE_RST(cfgl_pkg::PRE_RST), .POST_RST(cfgl_pkg::POST_RST), .FB_RST(cfgl_pkg::FB_RST)
   ) u_hold (
      .clk(clk), .rst_n(rst_n), .commit(load_rise), .word(word),
      .pre_q(pre_div), .post_q(post_code), .fb_q(fb_div), .upd_q(cfg_upd)
   );
endmodule

// File: rtl/cfgl_loader_chk.sv
module cfgl_loader_chk #(
   parameter int unsigned PRE_W     = 5,
   parameter int unsigned POST_W    = 3,
   parameter int unsigned FB_W      = 10,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned W        = PRE_W + POST_W + FB_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk_rise,
   input logic              load_rise,
   input logic              din_s,
   input logic [W-1:0]      word,
   input logic [PRE_W-1:0]  pre_div,
   input logic [POST_W-1:0] post_code,
   input logic [FB_W-1:0]   fb_div,
   input logic              cfg_upd
);
   logic [W-1:0] fields;
   logic         ins_bit;
   assign fields  = {pre_div, post_code, fb_div};
   assign ins_bit = MSB_FIRST ? word[0] : word[W-1];

   p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pre_div == PRE_W'(cfgl_pkg::PRE_RST)) &&
                       (post_code == POST_W'(cfgl_pkg::POST_RST)) &&
                       (fb_div == FB_W'(cfgl_pkg::FB_RST)) && !cfg_upd);

   p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> ins_bit == $past(din_s));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_upd |-> $stable(fields));

   p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_rise |=> fields == $past(word));

   p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_upd |-> $past(load_rise));

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_upd |=> !cfg_upd);
endmodule

bind cfgl_serial_loader cfgl_loader_chk #(
   .PRE_W(PRE_W), .POST_W(POST_W), .FB_W(FB_W), .MSB_FIRST(MSB_FIRST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .load_rise(load_rise),
   .din_s(din_s), .word(word), .pre_div(pre_div), .post_code(post_code),
   .fb_div(fb_div), .cfg_upd(cfg_upd)
);

// File: tb/cfgl_serial_loader_test.sv
`timescale 1ns/1ps
module cfgl_serial_loader_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
   logic [4:0] pre_div;
   logic [2:0] post_code;
   logic [9:0] fb_div;
   logic       cfg_upd;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [17:0] sent = '0;
   logic [17:0] held = {5'd1, 3'd0, 10'd1};

   always #2 clk = ~clk;

   cfgl_serial_loader uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
      .pre_div(pre_div), .post_code(post_code), .fb_div(fb_div), .cfg_upd(cfg_upd)
   );

   function automatic logic [17:0] outs_now();
      return {pre_div, post_code, fb_div};
   endfunction

   task automatic chk(input logic [17:0] act, input logic [17:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      ser_dat = b;
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      sent = {sent[16:0], b};
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic do_load(input string tag);
      @(negedge clk);
      ser_ld = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1;
      chk(outs_now(), held, {tag, " R4 old value held before commit"});
      chk({17'd0, cfg_upd}, 18'd0, {tag, " R5 no pulse before commit"});
      held = sent;
      @(posedge clk);
      #1;
      chk(outs_now(), held, {tag, " R2 R4 fields after commit"});
      chk({17'd0, cfg_upd}, 18'd1, {tag, " R5 pulse at commit"});
      @(posedge clk);
      #1;
      chk({17'd0, cfg_upd}, 18'd0, {tag, " R5 pulse one cycle"});
      repeat (4) @(negedge clk);
      ser_ld = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (80000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed;
      logic [17:0] w;
      seed = $urandom(32'h5eed_1234);
      repeat (3) @(negedge clk);
      #0;
      chk(outs_now(), {5'd1, 3'd0, 10'd1}, "R1 fields in reset");
      chk({17'd0, cfg_upd}, 18'd0, "R1 pulse in reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(outs_now(), {5'd1, 3'd0, 10'd1}, "R1 fields after reset");
      chk({17'd0, cfg_upd}, 18'd0, "R1 pulse after reset");

      // directed: first bit must land in pre_div[4], last in fb_div[0]
      send_bits(32'h20001, 18);
      chk(outs_now(), held, "R3 no change while shifting");
      do_load("R2 end bits");

      send_bits(32'h3FFFE, 18);
      chk(outs_now(), held, "R3 no change while shifting");
      do_load("R2 inverse");

      // field boundary pattern: pre=10101, post=011, fb=1100110011
      send_bits({14'd0, 5'b10101, 3'b011, 10'b1100110011}, 18);
      do_load("R2 fields");

      // R6: 23 bits, only the last 18 count
      send_bits(32'h7FFFFF & 32'h5A5A5A, 23);
      do_load("R6 overlong frame");

      // R8: reload same word
      do_load("R8 reload");

      // R7: hold load high and pulse it low, no extra update
      @(negedge clk);
      ser_ld = 1'b1;
      repeat (3) @(negedge clk);
      ser_ld = 1'b0;
      send_bits(32'h2AAAA, 18);
      repeat (2) @(negedge clk);
      ser_ld = 1'b1;
      held = sent;
      repeat (8) @(negedge clk);
      chk(outs_now(), held, "R7 setting after held strobe");
      chk({17'd0, cfg_upd}, 18'd0, "R7 no pulse while held");
      send_bits(32'h15555, 18);
      ser_ld = 1'b0;
      repeat (8) @(negedge clk);
      chk(outs_now(), held, "R7 R3 falling edge and shift while high ignored");
      chk({17'd0, cfg_upd}, 18'd0, "R7 no pulse on fall");

      // random frames
      for (int k = 0; k < 8; k++) begin
         w = 18'($urandom());
         send_bits({14'd0, w}, 18);
         chk(outs_now(), held, "R3 random shift no change");
         do_load("R2 random frame");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule